// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit segment value and an offset into a linear address. A mode input chooses between two schemes. With the mode low, the segment is a paragraph number: it is shifted left by four bits and the low 16 bits of the offset are added, which gives a 20-bit address. With the mode high, the segment is a selector. Its index field picks an 8-byte descriptor from a descriptor table in memory. The 32-bit base held in that descriptor is then added to the full 32-bit offset.

Two table registers arrive as inputs, each a 32-bit base and a 16-bit limit. The global table is always present. The local table is optional and has a presence flag. A descriptor is fetched over a read port that allows one outstanding read and that handshakes with a done pulse. The block keeps a one-entry cache of the last descriptor base it fetched, so a repeated selector is translated without touching memory.

Translation requests use a valid/ready handshake, and only one request is in flight at a time. Each result appears as a single-cycle response pulse that carries either an address or a fault.

Top module: `seg_xlate`

## Requirements
- R1: With `pe_mode` low at acceptance, `rsp_addr` equals ((`req_seg` << 4) + `req_off[15:0]`) modulo 2^20, zero-extended to 32 bits, with `rsp_fault` low. `rsp_valid` rises in the cycle right after acceptance, and `req_off[31:16]` has no effect.
- R2: With `pe_mode` high, selector bit 2 picks the table (0 global, 1 local) and bits 15:3 form the index. The descriptor address is the chosen table base plus index times 8.
- R3: A descriptor is read as two 32-bit words: first at the descriptor address, then at that address plus 4. Each read holds `mem_rd_valid` high and `mem_rd_addr` stable until the cycle in which `mem_rd_done` is seen.
- R4: The descriptor base is {high[31:24], high[7:0], low[31:16]}. `rsp_addr` is that base plus `req_off`, modulo 2^32. `rsp_valid` rises in the cycle after the second `mem_rd_done`.
- R5: If index*8+7 is greater than the chosen table limit, the response comes in the cycle after acceptance with `rsp_fault` high and `rsp_addr` zero, and no memory read is issued. A descriptor whose last byte lands exactly on the limit is accepted.
- R6: A selector with bit 2 set while `ltab_present` is low faults in the cycle after acceptance, and no memory read is issued.
- R7: A protected request whose full 16-bit selector equals that of the last completed fetch, with the cache still valid, is answered in the cycle after acceptance from the cached base, and no memory read is issued. The cache holds a single entry.
- R8: Any change to a table base, a table limit or `ltab_present`, or any cycle with `pe_mode` low, empties the cache, so the next protected request fetches its descriptor again.
- R9: `req_ready` is high only when no request is in progress, and `mem_rd_valid` is never high while `req_ready` is high. After reset, `req_ready` is high and `rsp_valid` and `mem_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_mode | input | 1 | 1 selects selector/descriptor translation, 0 selects shift-and-add |
| gtab_base | input | 32 | Global descriptor table base |
| gtab_limit | input | 16 | Global descriptor table limit in bytes |
| ltab_base | input | 32 | Local descriptor table base |
| ltab_limit | input | 16 | Local descriptor table limit in bytes |
| ltab_present | input | 1 | Local table exists |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Result is a fault; address is zero |
| rsp_addr | output | 32 | Linear address |
| mem_rd_valid | output | 1 | Descriptor word read pending |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rd_done | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Read data, valid with `mem_rd_done` |

## Verification
The hardest case to reach is a cache entry that has gone stale. A selector that hits must miss again after a table register changes, or after a single real-mode request passes through, even though the selector itself is unchanged. The bench reaches this by translating one selector twice and seeing no memory traffic the second time. It then changes a register that the selector does not even use, or sends one real-mode request, and requires the same selector to produce both descriptor reads again. Limit faults are driven at the exact last legal index and one index beyond it, in both tables.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2
  } xl_state_e;

  // Descriptor base scattered over the two words of a 64-bit descriptor.
  function automatic logic [31:0] desc_base(input logic [31:0] lo_w,
                                            input logic [31:0] hi_w);
    return {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
  endfunction

endpackage

// File: rtl/seg_real_calc.sv
module seg_real_calc #(
  parameter int SEG_W  = 16,
  parameter int REAL_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [SEG_W-1:0]  off_lo,
  output logic [REAL_W-1:0] real_addr
);
  localparam int SHIFT = REAL_W - SEG_W;

  logic [REAL_W-1:0] seg_sh;
  logic [REAL_W-1:0] off_ext;

  always_comb begin
    seg_sh    = {seg, {SHIFT{1'b0}}};
    off_ext   = {{SHIFT{1'b0}}, off_lo};
    real_addr = seg_sh + off_ext;
  end
endmodule

// File: rtl/seg_desc_chk.sv
module seg_desc_chk #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [SEG_W-1:2]  sel_hi,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [SEG_W-1:0]  glim,
  input  logic [ADDR_W-1:0] lbase,
  input  logic [SEG_W-1:0]  llim,
  input  logic              lpresent,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              fault
);
  localparam int IDX_W = SEG_W - 3;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [SEG_W-1:0]  last_byte;
  logic [SEG_W-1:0]  lim;
  logic [ADDR_W-1:0] base;

  always_comb begin
    idx       = sel_hi[SEG_W-1:3];
    use_local = sel_hi[2];
    lim       = use_local ? llim  : glim;
    base      = use_local ? lbase : gbase;
    last_byte = {idx, 3'b111};
    desc_addr = base + {{(ADDR_W-SEG_W){1'b0}}, idx, 3'b000};
    fault     = (use_local && !lpresent) || (last_byte > lim);
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill,
  input  logic [SEG_W-1:0]  fill_sel,
  input  logic [ADDR_W-1:0] fill_base,
  input  logic [SEG_W-1:0]  look_sel,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_base
);
  logic              valid_q, valid_d;
  logic [SEG_W-1:0]  sel_q, sel_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              ld_en;

  always_comb begin
    valid_d = valid_q;
    ld_en   = fill && !flush;
    sel_d   = fill_sel;
    base_d  = fill_base;
    if (ld_en) valid_d = 1'b1;
    if (flush) valid_d = 1'b0;
    hit      = valid_q && !flush && (sel_q == look_sel);
    hit_base = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
      base_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (ld_en) begin
        sel_q  <= sel_d;
        base_q <= base_d;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 32,
  parameter int REAL_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_mode,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [SEG_W-1:0]  gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [SEG_W-1:0]  ltab_limit,
  input  logic              ltab_present,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_off,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_done,
  input  logic [ADDR_W-1:0] mem_rd_data
);
  import seg_xlate_pkg::*;

  localparam int TBL_W  = 2*ADDR_W + 2*SEG_W + 1;
  localparam int WORD_B = ADDR_W / 8;

  xl_state_e         state_q, state_d;
  logic [SEG_W-1:0]  sel_q, sel_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic [ADDR_W-1:0] lo_q, lo_d;
  logic              rv_q, rv_d;
  logic              rf_q, rf_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic [TBL_W-1:0]  tbl_q, tbl_now;

  logic [REAL_W-1:0] real_addr;
  logic [ADDR_W-1:0] desc_addr;
  logic              chk_fault;
  logic              c_hit, c_fill, c_flush;
  logic [ADDR_W-1:0] c_base, new_base;
  logic              accept;

  seg_real_calc #(.SEG_W(SEG_W), .REAL_W(REAL_W)) real_i (
    .seg       (req_seg),
    .off_lo    (req_off[SEG_W-1:0]),
    .real_addr (real_addr)
  );

  seg_desc_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) chk_i (
    .sel_hi    (req_seg[SEG_W-1:2]),
    .gbase     (gtab_base),
    .glim      (gtab_limit),
    .lbase     (ltab_base),
    .llim      (ltab_limit),
    .lpresent  (ltab_present),
    .desc_addr (desc_addr),
    .fault     (chk_fault)
  );

  seg_desc_cache #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) cache_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (c_flush),
    .fill      (c_fill),
    .fill_sel  (sel_q),
    .fill_base (new_base),
    .look_sel  (req_seg),
    .hit       (c_hit),
    .hit_base  (c_base)
  );

  // Table register snapshot: any difference empties the cache.
  always_comb begin
    tbl_now = {gtab_base, gtab_limit, ltab_base, ltab_limit, ltab_present};
    c_flush = !pe_mode || (tbl_now != tbl_q);
    accept  = req_valid && (state_q == ST_IDLE);
    new_base = desc_base(lo_q, mem_rd_data);
  end

  always_comb begin
    state_d   = state_q;
    sel_d     = sel_q;
    off_d     = off_q;
    rd_addr_d = rd_addr_q;
    lo_d      = lo_q;
    rv_d      = 1'b0;
    rf_d      = 1'b0;
    ra_d      = '0;
    c_fill    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!pe_mode) begin
            rv_d = 1'b1;
            ra_d = {{(ADDR_W-REAL_W){1'b0}}, real_addr};
          end else if (chk_fault) begin
            rv_d = 1'b1;
            rf_d = 1'b1;
          end else if (c_hit) begin
            rv_d = 1'b1;
            ra_d = c_base + req_off;
          end else begin
            state_d   = ST_RD_LO;
            sel_d     = req_seg;
            off_d     = req_off;
            rd_addr_d = desc_addr;
          end
        end
      end
      ST_RD_LO: begin
        if (mem_rd_done) begin
          lo_d      = mem_rd_data;
          rd_addr_d = rd_addr_q + ADDR_W'(WORD_B);
          state_d   = ST_RD_HI;
        end
      end
      ST_RD_HI: begin
        if (mem_rd_done) begin
          c_fill  = 1'b1;
          rv_d    = 1'b1;
          ra_d    = new_base + off_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      off_q     <= '0;
      rd_addr_q <= '0;
      lo_q      <= '0;
      rv_q      <= 1'b0;
      rf_q      <= 1'b0;
      ra_q      <= '0;
      tbl_q     <= '0;
    end else begin
      state_q   <= state_d;
      sel_q     <= sel_d;
      off_q     <= off_d;
      rd_addr_q <= rd_addr_d;
      lo_q      <= lo_d;
      rv_q      <= rv_d;
      rf_q      <= rf_d;
      ra_q      <= ra_d;
      tbl_q     <= tbl_now;
    end
  end

  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    mem_rd_valid = (state_q != ST_IDLE);
    mem_rd_addr  = rd_addr_q;
    rsp_valid    = rv_q;
    rsp_fault    = rf_q;
    rsp_addr     = ra_q;
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 32,
  parameter int REAL_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pe_mode,
  input logic              ltab_present,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEG_W-1:0]  req_seg,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_done
);
  AST_REAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !pe_mode |=> rsp_valid && !rsp_fault && (rsp_addr[ADDR_W-1:REAL_W] == '0)); // R1

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_done |=> mem_rd_valid && $stable(mem_rd_addr)); // R3

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_done |=> rsp_valid || (mem_rd_valid && (mem_rd_addr == $past(mem_rd_addr) + 32'd4))); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && (rsp_addr == '0)); // R5

  AST_LOCAL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && pe_mode && req_seg[2] && !ltab_present |=> rsp_valid && rsp_fault && !mem_rd_valid); // R6

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid); // R9
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .REAL_W(REAL_W)) chk_bind_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pe_mode      (pe_mode),
  .ltab_present (ltab_present),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_seg      (req_seg),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_addr     (rsp_addr),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_done  (mem_rd_done)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pe_mode;
  logic [31:0] gtab_base, ltab_base;
  logic [15:0] gtab_limit, ltab_limit;
  logic        ltab_present;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_seg;
  logic [31:0] req_off;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_done;
  logic [31:0] mem_rd_data;

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .pe_mode(pe_mode),
    .gtab_base(gtab_base), .gtab_limit(gtab_limit),
    .ltab_base(ltab_base), .ltab_limit(ltab_limit), .ltab_present(ltab_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        fault;
    logic [31:0] addr;
    logic        quick;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] rd_q[$];
  int checks = 0;
  int errors = 0;
  int pcnt   = 0;
  int done_p = 0;
  int rd_num = 0;

  logic        m_valid;
  logic [15:0] m_sel;
  logic [31:0] m_base;

  always @(posedge clk) pcnt <= pcnt + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: computes the expected result from the requirements and pushes it.
  task automatic xlate(input logic pe, input logic [15:0] seg, input logic [31:0] off, input string tag);
    exp_t e;
    logic [15:0] lim, last_b;
    logic [31:0] tb, da;
    e.tag = tag; e.fault = 1'b0; e.quick = 1'b1; e.addr = '0;
    if (!pe) begin
      e.addr = {12'h0, ({seg, 4'h0} + {4'h0, off[15:0]})};
      m_valid = 1'b0;
    end else begin
      lim    = seg[2] ? ltab_limit : gtab_limit;
      tb     = seg[2] ? ltab_base  : gtab_base;
      last_b = {seg[15:3], 3'b111};
      if ((seg[2] && !ltab_present) || (last_b > lim)) begin
        e.fault = 1'b1;
      end else if (m_valid && m_sel == seg) begin
        e.addr = m_base + off;
      end else begin
        da = tb + {16'h0, seg[15:3], 3'b000};
        rd_q.push_back(da);
        rd_q.push_back(da + 32'd4);
        m_base  = {mem_word(da+32'd4)[31:24], mem_word(da+32'd4)[7:0], mem_word(da)[31:16]};
        m_sel   = seg;
        m_valid = 1'b1;
        e.addr  = m_base + off;
        e.quick = 1'b0;
      end
    end
    exp_q.push_back(e);
    while (!req_ready) @(negedge clk);
    pe_mode = pe; req_seg = seg; req_off = off; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.quick) check(rsp_valid === 1'b1, {tag, " one-cycle response"}, {31'h0, rsp_valid}, 32'h1);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic set_tables(input logic [31:0] gb, input logic [15:0] gl,
                            input logic [31:0] lb, input logic [15:0] ll, input logic lp);
    gtab_base = gb; gtab_limit = gl; ltab_base = lb; ltab_limit = ll; ltab_present = lp;
    m_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops and compares each response.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_addr, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_fault === e.fault, {e.tag, " fault flag"}, {31'h0, rsp_fault}, {31'h0, e.fault});
        check(rsp_addr === e.addr, {e.tag, " address"}, rsp_addr, e.addr);
        if (!e.quick)
          check(pcnt == done_p + 1, "R4 response cycle after second read", pcnt, done_p + 1);
      end
    end
  end

  // Memory model: checks read addresses and order, answers after a delay.
  initial begin
    mem_rd_done = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_rd_valid === 1'b1) begin
        logic [31:0] a, expa;
        a = mem_rd_addr;
        if (rd_q.size() == 0) begin
          check(1'b0, "R7 R9 unexpected memory read", a, 32'h0);
          expa = a;
        end else begin
          expa = rd_q.pop_front();
          check(a === expa, "R2 R3 descriptor read address", a, expa);
        end
        for (int k = 0; k < rd_num % 3; k++) begin
          @(negedge clk);
          check(mem_rd_valid === 1'b1 && mem_rd_addr === a, "R3 read held stable", mem_rd_addr, a);
        end
        rd_num++;
        mem_rd_done = 1'b1;
        mem_rd_data = mem_word(a);
        done_p = pcnt;
        @(negedge clk);
        mem_rd_done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pe_mode = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0;
    gtab_base = 32'h0010_0000; gtab_limit = 16'h00FF;
    ltab_base = 32'h0020_0404; ltab_limit = 16'h003F; ltab_present = 1'b1;
    m_valid = 1'b0; m_sel = '0; m_base = '0;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R9 reset ready", {31'h0, req_ready}, 32'h1);
    check(rsp_valid === 1'b0, "R9 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(mem_rd_valid === 1'b0, "R9 reset mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    xlate(1'b0, 16'h1234, 32'h0000_0010, "R1 real basic");
    xlate(1'b0, 16'hFFFF, 32'h0000_FFFF, "R1 real wrap 20 bits");
    xlate(1'b0, 16'h0000, 32'hABCD_0001, "R1 real upper offset ignored");

    xlate(1'b1, 16'h0008, 32'h0000_0100, "R2 R4 global fetch");
    xlate(1'b1, 16'h0008, 32'h0000_0200, "R7 repeat selector hit");
    xlate(1'b1, 16'h000C, 32'h0000_0033, "R2 R4 local fetch");
    xlate(1'b1, 16'h000C, 32'hFFFF_FFFF, "R7 local hit offset wrap");
    xlate(1'b1, 16'h0008, 32'h0000_0004, "R7 one entry evicted refetch");
    xlate(1'b1, 16'h000B, 32'h0000_0004, "R7 different low bits refetch");

    xlate(1'b1, 16'h00F8, 32'h0000_1000, "R5 global last legal index");
    xlate(1'b1, 16'h0100, 32'h0000_1000, "R5 global index past limit");
    xlate(1'b1, 16'h003C, 32'h0000_0001, "R5 local last legal index");
    xlate(1'b1, 16'h0044, 32'h0000_0001, "R5 local index past limit");
    xlate(1'b1, 16'h003C, 32'h0000_0002, "R7 hit after faults");

    set_tables(32'h0010_0000, 16'h00FF, 32'h0020_0404, 16'h003F, 1'b0);
    xlate(1'b1, 16'h000C, 32'h0000_0000, "R6 local table absent");
    xlate(1'b1, 16'h0010, 32'h0000_0040, "R8 fetch after table change");
    xlate(1'b1, 16'h0010, 32'h0000_0041, "R7 hit before invalidation");
    set_tables(32'h0010_0000, 16'h00FF, 32'h0030_0000, 16'h003F, 1'b1);
    xlate(1'b1, 16'h0010, 32'h0000_0042, "R8 refetch after local base change");
    xlate(1'b0, 16'h0010, 32'h0000_0042, "R1 real between protected");
    xlate(1'b1, 16'h0010, 32'h0000_0043, "R8 refetch after real-mode cycle");
    set_tables(32'h00FF_FFF8, 16'h00FF, 32'h0030_0000, 16'h003F, 1'b1);
    xlate(1'b1, 16'h0018, 32'h8000_0000, "R2 R4 base near top");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 32'h0);
    check(rd_q.size() == 0, "R3 all reads issued", rd_q.size(), 32'h0);
    finish_run();
  end
endmodule